// File: doc/BRIEF.md
# Byte Table Lookup Unit

This block performs a byte-granular table lookup over a small table of 64-bit registers. A 32-bit index word carries four independent 8-bit indices. Each index picks one byte out of a table that holds one to four 64-bit registers, which arrive packed side by side in a 256-bit vector. The chosen byte is placed in the same byte lane of the 32-bit result that the index came from.

A 2-bit-plus count input says how many table registers are in use. Any index that points past the last register in use is out of range. For such an index the lane is filled from the matching byte of a 32-bit fallback word rather than being forced to zero. This lets a caller chain several lookups over wider tables, feeding the previous partial result in as the fallback word.

The lookup itself is combinational. A parameter adds an output register with a valid strobe, which is present by default, so the lookup can be placed at the end of a timing-critical stage.

Top module: `btl_lookup`

## Requirements
- R1: Each of the four index bytes `index_word[8L+7:8L]` (L = 0..3) is resolved on its own, and its result lands in `result[8L+7:8L]`; the lanes do not affect each other.
- R2: An index is in range only when it is strictly less than 8 times the effective register count. A count of 0 leaves every lane out of range, so the result equals the fallback word.
- R3: For an in-range index, bits [7:3] pick table register k, which sits at `table_vec[64k+63:64k]`, and bits [2:0] pick a byte inside that register, byte 0 being bits [7:0] of the register.
- R4: For an out-of-range index, the lane takes the byte in the same lane of `default_word`.
- R5: `reg_count` values 1, 2, 3 and 4 give 8, 16, 24 and 32 valid indices; values 5 to 7 are treated as 4.
- R6: Table registers at or above the effective count never influence the result.
- R7: With the output register enabled, a lookup presented with `in_valid` high appears on `result`, with `out_valid` high, exactly one clock later. `out_valid` is low in every cycle that follows a cycle with `in_valid` low. After reset, `result` is 0 and `out_valid` is 0.
- R8: With the output register enabled, `result` keeps its value across any cycle in which `in_valid` is low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks a lookup request in this cycle |
| index_word | input | 32 | Four 8-bit table indices, one per byte lane |
| default_word | input | 32 | Fallback bytes for out-of-range lanes |
| table_vec | input | 256 | Up to four packed 64-bit table registers, register k at bits [64k+63:64k] |
| reg_count | input | 3 | Number of table registers in use (1 to 4; 0 means none, above 4 clamps to 4) |
| result | output | 32 | Looked-up bytes merged into one word |
| out_valid | output | 1 | High when `result` carries a new lookup |

## Verification
A wrong range limit shows up on the very next valid result as a lane that holds a fallback byte where a table byte was due, or the reverse. The bench biases indices around the 8, 16, 24 and 32 borders so such a slip is caught within a few lookups. A wrong register or byte select gives a misplaced table byte in the affected lane one cycle after the request. A stale or wrongly enabled output register shows as a changed `result` or a missing strobe in the cycle right after an idle or active input cycle.

// File: rtl/btl_pkg.sv
`timescale 1ns/1ps
// Shared sizes for the byte table lookup unit.
// Assumes byte-wide indices and a table of whole registers.
package btl_pkg;
    localparam int BYTE_W     = 8;                        // bits per byte lane
    localparam int LANES      = 4;                        // index bytes per word
    localparam int REG_BYTES  = 8;                        // bytes per table register
    localparam int MAX_REGS   = 4;                        // table registers at most
    localparam int REG_W      = BYTE_W * REG_BYTES;       // width of one register
    localparam int TABLE_W    = REG_W * MAX_REGS;         // packed table width
    localparam int WORD_W     = BYTE_W * LANES;           // index/result width
    localparam int BYTE_SEL_W = $clog2(REG_BYTES);        // byte-in-register bits
    localparam int REG_SEL_W  = BYTE_W - BYTE_SEL_W;      // register select bits
    localparam int CNT_W      = $clog2(MAX_REGS + 1);     // register count width
    localparam int LIMIT_W    = BYTE_W + 1;               // holds limit up to 256
endpackage

// File: rtl/btl_limit.sv
`timescale 1ns/1ps
// Turns the register count into the exclusive upper bound on valid indices.
// Assumes counts above MAX_REGS are to be clamped, and 0 yields an empty table.
module btl_limit
    import btl_pkg::*;
(
    input  logic [CNT_W-1:0]   cnt_i,
    output logic [LIMIT_W-1:0] limit_o
);
    logic [CNT_W-1:0] eff_cnt;

    // clamp the count to the number of registers that exist
    always_comb begin
        if (cnt_i > CNT_W'(MAX_REGS)) eff_cnt = CNT_W'(MAX_REGS);
        else                           eff_cnt = cnt_i;
    end

    // scale registers to bytes
    always_comb limit_o = LIMIT_W'(eff_cnt) * LIMIT_W'(REG_BYTES);
endmodule

// File: rtl/btl_lane.sv
`timescale 1ns/1ps
// One byte lane of the lookup: picks a table byte or the fallback byte.
// Assumes limit_i never exceeds the table size in bytes.
module btl_lane
    import btl_pkg::*;
(
    input  logic [BYTE_W-1:0]  idx_i,
    input  logic [BYTE_W-1:0]  dflt_i,
    input  logic [LIMIT_W-1:0] limit_i,
    input  logic [TABLE_W-1:0] table_i,
    output logic [BYTE_W-1:0]  byte_o
);
    logic [REG_SEL_W-1:0]  reg_sel;
    logic [BYTE_SEL_W-1:0] byte_sel;
    logic [REG_W-1:0]      reg_word;
    logic                  in_range;

    assign reg_sel  = idx_i[BYTE_W-1:BYTE_SEL_W];
    assign byte_sel = idx_i[BYTE_SEL_W-1:0];
    assign in_range = {1'b0, idx_i} < limit_i;

    // register mux: pick the addressed 64-bit register, zero if none matches
    always_comb begin
        reg_word = '0;
        for (int k = 0; k < MAX_REGS; k++) begin
            if (reg_sel == REG_SEL_W'(k)) reg_word = table_i[k*REG_W +: REG_W];
        end
    end

    // byte mux: table byte when in range, otherwise the fallback byte
    always_comb begin
        if (in_range) byte_o = reg_word[byte_sel*BYTE_W +: BYTE_W];
        else          byte_o = dflt_i;
    end
endmodule

// File: rtl/btl_lookup.sv
`timescale 1ns/1ps
// Top of the byte table lookup unit: four lanes share one range limit,
// and an optional output register adds a valid strobe.
// Assumes reg_count is stable while in_valid is high.
module btl_lookup
    import btl_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  index_word,
    input  logic [WORD_W-1:0]  default_word,
    input  logic [TABLE_W-1:0] table_vec,
    input  logic [CNT_W-1:0]   reg_count,
    output logic [WORD_W-1:0]  result,
    output logic               out_valid
);
    logic [LIMIT_W-1:0] limit;
    logic [WORD_W-1:0]  lookup_word;

    btl_limit u_limit (
        .cnt_i   (reg_count),
        .limit_o (limit)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        btl_lane u_lane (
            .idx_i   (index_word[l*BYTE_W +: BYTE_W]),
            .dflt_i  (default_word[l*BYTE_W +: BYTE_W]),
            .limit_i (limit),
            .table_i (table_vec),
            .byte_o  (lookup_word[l*BYTE_W +: BYTE_W])
        );
    end

    if (REG_OUT) begin : g_reg
        logic [WORD_W-1:0] result_q;
        logic              valid_q;

        // output stage: capture a lookup when requested, strobe valid
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                result_q <= '0;
                valid_q  <= 1'b0;
            end else begin
                valid_q <= in_valid;
                if (in_valid) result_q <= lookup_word;
            end
        end

        assign result    = result_q;
        assign out_valid = valid_q;

        // R7: a request yields a strobe one cycle later
        a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        // R7: no request, no strobe
        a_r7_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        // R8: idle cycles leave the result untouched
        a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(result));
        // R2: an empty table returns the fallback word
        a_r2_empty_table: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && reg_count == '0) |=> (result == $past(default_word)));
    end else begin : g_comb
        assign result    = lookup_word;
        assign out_valid = in_valid;
    end
endmodule

// File: tb/tb_btl_lookup.sv
`timescale 1ns/1ps
module tb_btl_lookup;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  index_word = '0;
    logic [31:0]  default_word = '0;
    logic [255:0] table_vec = '0;
    logic [2:0]   reg_count = 3'd1;
    logic [31:0]  result;
    logic         out_valid;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] exp_res = '0;
    logic        exp_vld = 1'b0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    btl_lookup dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .index_word(index_word), .default_word(default_word),
        .table_vec(table_vec), .reg_count(reg_count),
        .result(result), .out_valid(out_valid)
    );

    // behavioural model: byte b of the whole table lives at bit 8*b
    function automatic logic [31:0] model(input logic [31:0] idx, input logic [31:0] dflt,
                                          input logic [255:0] tab, input int cnt);
        int lim;
        logic [31:0] r;
        lim = ((cnt > 4) ? 4 : cnt) * 8;
        for (int l = 0; l < 4; l++) begin
            int b;
            b = int'(idx[8*l +: 8]);
            if (b < lim) r[8*l +: 8] = tab[8*b +: 8];
            else         r[8*l +: 8] = dflt[8*l +: 8];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock of stimulus, model update and comparison
    task automatic step(input logic v, input logic [31:0] idx, input logic [31:0] dflt,
                        input logic [255:0] tab, input logic [2:0] cnt, input string tag);
        in_valid = v; index_word = idx; default_word = dflt;
        table_vec = tab; reg_count = cnt;
        @(posedge clk);
        exp_vld = v;
        if (v) exp_res = model(idx, dflt, tab, int'(cnt));
        @(negedge clk);
        check({tag, " R7 strobe"}, {31'd0, out_valid}, {31'd0, exp_vld});
        check(tag, result, exp_res);
    endtask

    function automatic logic [255:0] rnd_table();
        logic [255:0] t;
        for (int i = 0; i < 8; i++) t[32*i +: 32] = $urandom;
        return t;
    endfunction

    function automatic logic [31:0] rnd_idx(input bit wide);
        logic [31:0] x;
        for (int l = 0; l < 4; l++)
            x[8*l +: 8] = wide ? 8'($urandom_range(0, 255)) : 8'($urandom_range(0, 40));
        return x;
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [255:0] t;
        logic [255:0] t2;
        repeat (3) @(negedge clk);
        check("R7 reset result", result, 32'h0);
        check("R7 reset strobe", {31'd0, out_valid}, 32'h0);
        rst_n = 1'b1;

        t = rnd_table();
        // R3: walk every byte of every register with a full table
        for (int b = 0; b < 32; b += 4)
            step(1'b1, {8'(b+3), 8'(b+2), 8'(b+1), 8'(b)}, 32'hDEADBEEF, t, 3'd4, "R3 walk");
        // R1: lanes independent, mixed in/out of range
        step(1'b1, 32'h1F_40_00_07, 32'hA1B2C3D4, t, 3'd4, "R1 mixed lanes");
        // R5: each count around its border
        for (int c = 1; c <= 4; c++) begin
            step(1'b1, {8'(8*c), 8'(8*c-1), 8'(8*c+1), 8'(8*c-8)}, 32'h11223344, t,
                 3'(c), "R5 border");
        end
        // R5: counts above 4 clamp to 4
        for (int c = 5; c <= 7; c++)
            step(1'b1, 32'h20_1F_18_10, 32'h55667788, t, 3'(c), "R5 clamp");
        // R2: count 0 gives the fallback word
        step(1'b1, 32'h00_01_02_03, 32'hCAFEF00D, t, 3'd0, "R2 empty table");
        // R4: every lane out of range
        step(1'b1, 32'hFF_80_20_10, 32'h0BADC0DE, t, 3'd2, "R4 all fallback");
        // R6: upper registers change, result must not
        t2 = t;
        t2[255:64] = ~t[255:64];
        step(1'b1, 32'h07_05_03_00, 32'h12345678, t, 3'd1, "R6 upper regs A");
        step(1'b1, 32'h07_05_03_00, 32'h12345678, t2, 3'd1, "R6 upper regs B");
        check("R6 same result", result, model(32'h07050300, 32'h12345678, t, 1));
        // R8: idle cycle with all inputs changing
        step(1'b0, 32'h01020304, 32'hFFFFFFFF, rnd_table(), 3'd3, "R8 hold");
        step(1'b0, 32'h1F1E1D1C, 32'h00000000, rnd_table(), 3'd4, "R8 hold");
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            step(($urandom_range(0, 3) != 0), rnd_idx($urandom_range(0, 4) == 0),
                 $urandom, rnd_table(), 3'($urandom_range(0, 7)), "R1 R3 R4 random");
        end
        // R7: reset mid-stream clears the outputs
        in_valid = 1'b1; rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R7 re-reset result", result, 32'h0);
        check("R7 re-reset strobe", {31'd0, out_valid}, 32'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule